// File: doc/BRIEF.md
# Video Switch Sink Routing Controller

This block is the control core of a four-source, two-sink video port switch. Each of the two sink ports picks one of four source ports. The block turns that choice into four things: a select code for the high-speed and DDC multiplexers, an enable for each sink's high-speed output driver, an enable for each sink-side DDC driver, and hot-plug levels returned to the sources. It also enables each source-side DDC buffer from that source's power-present input, and it mirrors the selected source's power-present level to each sink.

Two configuration sets are kept. One is taken from dedicated control pins and passes through a two-flop synchronizer. The other is held in a small write-only register file. A mode pin, which is synchronized the same way, chooses which set is live. Power-present and hot-plug inputs are treated as asynchronous levels and act combinationally on the outputs. The analog data path is not part of this block.

Top module: `vsw_route_ctrl`

## Requirements
- R1: Sink k's source select is the 2-bit field `snk_sel[2k+1:2k]`, where code 0, 1, 2 or 3 picks source port 0, 1, 2 or 3. `snk_pwr[k]` equals `src_pwr` of the selected source.
- R2: `snk_hs_en[k]` is high only when sink k's active-low output-enable control is 0 and `src_pwr` of its selected source is 1. It is low in every other case.
- R3: `src_hpd[s]` is 0 when no sink selects source s. When exactly one sink selects s, `src_hpd[s]` equals that sink's `snk_hpd`.
- R4: When both sinks select the same source, that source's `src_hpd` follows the hot-plug input of the priority sink: sink 0 when the priority bit is 0, sink 1 when it is 1.
- R5: `snk_ddc_en[k]` equals sink k's DDC grant AND the selected source's `src_pwr` while power gating is active. Power gating is active when the mode is pins, or when the mode is registers and the gate bit is 1. Otherwise `snk_ddc_en[k]` equals the grant alone.
- R6: With `gpio_mode`=1, all controls come from the pins, and the register gate bit is ignored. With `gpio_mode`=0, all controls come from the registers.
- R7: `src_ddc_en[s]` equals `src_pwr[s]` for every source.
- R8: A write with `reg_we`=1 takes effect on the next clock edge. Address 1 holds sink 0 and address 2 holds sink 1, with these fields: bits 1:0 select, bit 2 active-low output enable, bit 3 DDC grant. Address 3 holds the global fields: bit 4 gate and bit 5 priority. Writes to any other address, and the unused bits of each register, have no effect.
- R9: A change on the pin-mode inputs, including `gpio_mode`, reaches the outputs at the second rising clock edge after it.
- R10: After reset, register mode is in effect, both sink registers read as 0x03 (select 3, output enabled, DDC grant 0), and the global register reads as 0x10 (gate on, priority 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gpio_mode | input | 1 | 1 = controls from pins, 0 = from registers |
| gpio_sel | input | 4 | Pin source selects, 2 bits per sink |
| gpio_oe_n | input | 2 | Pin active-low high-speed output enables |
| gpio_ddc_en | input | 2 | Pin DDC driver grants |
| gpio_prio | input | 1 | Pin priority-sink bit |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 8 | Register write data |
| src_pwr | input | 4 | Source power-present levels |
| snk_hpd | input | 2 | Sink hot-plug levels |
| src_hpd | output | 4 | Hot-plug levels returned to sources |
| src_ddc_en | output | 4 | Source-side DDC buffer enables |
| snk_sel | output | 4 | Live source select per sink, 2 bits each |
| snk_hs_en | output | 2 | High-speed output enable per sink (1 = driving) |
| snk_ddc_en | output | 2 | Sink-side DDC driver enable |
| snk_pwr | output | 2 | Selected source power level per sink |

## Verification
A wrong configuration bit shows up on `snk_sel`, the enables or the hot-plug levels as soon as it becomes live. For a register it is live one edge after the write; for a pin it is live two edges after the change. The power and hot-plug paths have no register, so any error in the routing or gating logic appears in the same cycle as the input change. The cases the tests target are both sinks sharing a source under each priority value, a source that loses power while it is selected, and the gate bit being overridden by pin mode.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  localparam int SRC_N    = 4;
  localparam int SNK_N    = 2;
  localparam int SEL_W    = $clog2(SRC_N);
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 8;
  localparam int OE_BIT   = SEL_W;
  localparam int DDC_BIT  = SEL_W + 1;
  localparam int GATE_BIT = 4;
  localparam int PRIO_BIT = 5;
  localparam int GLOB_ADDR = SNK_N + 1;

  typedef struct packed {
    logic             ddc_en;
    logic             oe_n;
    logic [SEL_W-1:0] sel;
  } sink_cfg_t;

  typedef struct packed {
    logic prio;
    logic pwr_gate;
  } glob_cfg_t;

  localparam sink_cfg_t SINK_RST = '{ddc_en: 1'b0, oe_n: 1'b0, sel: {SEL_W{1'b1}}};
  localparam glob_cfg_t GLOB_RST = '{prio: 1'b0, pwr_gate: 1'b1};

  function automatic sink_cfg_t unpack_sink(input logic [DATA_W-1:0] d);
    sink_cfg_t c;
    c.sel    = d[SEL_W-1:0];
    c.oe_n   = d[OE_BIT];
    c.ddc_en = d[DDC_BIT];
    return c;
  endfunction

  function automatic glob_cfg_t unpack_glob(input logic [DATA_W-1:0] d);
    glob_cfg_t g;
    g.prio     = d[PRIO_BIT];
    g.pwr_gate = d[GATE_BIT];
    return g;
  endfunction

  function automatic logic pick_pwr(input logic [SRC_N-1:0] pwr, input logic [SEL_W-1:0] sel);
    return pwr[sel];
  endfunction

  function automatic logic hs_enable(input sink_cfg_t c, input logic pwr_sel);
    return ~c.oe_n & pwr_sel;
  endfunction

  function automatic logic ddc_enable(input sink_cfg_t c, input logic pwr_sel, input logic gate);
    return c.ddc_en & (pwr_sel | ~gate);
  endfunction
endpackage

// File: rtl/vsw_cfg_sync.sv
module vsw_cfg_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1_q, stage2_q;
  logic [1:0]   warm_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      warm_q   <= '0;
    end else begin
      stage1_q <= din;
      stage2_q <= stage1_q;
      if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end
  end

  assign dout = stage2_q;

  // output equals the input sampled two edges earlier
  assert_two_edge_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/vsw_cfg_regs.sv
module vsw_cfg_regs
  import vsw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  output sink_cfg_t [SNK_N-1:0]       sink_q,
  output glob_cfg_t                   glob_q
);
  logic [SNK_N-1:0] sink_hit;
  logic             glob_hit;

  always_comb begin
    for (int k = 0; k < SNK_N; k++) sink_hit[k] = we && (addr == ADDR_W'(k + 1));
    glob_hit = we && (addr == ADDR_W'(GLOB_ADDR));
  end

  for (genvar k = 0; k < SNK_N; k++) begin : g_sink_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           sink_q[k] <= SINK_RST;
      else if (sink_hit[k]) sink_q[k] <= unpack_sink(wdata);
    end

    assert_sink_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(k + 1)) |=> (sink_q[k].sel == $past(wdata[SEL_W-1:0])
                                         && sink_q[k].oe_n == $past(wdata[OE_BIT])));
    assert_sink_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && addr == ADDR_W'(k + 1)) |=> $stable(sink_q[k]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        glob_q <= GLOB_RST;
    else if (glob_hit) glob_q <= unpack_glob(wdata);
  end
endmodule

// File: rtl/vsw_sink_path.sv
module vsw_sink_path
  import vsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  sink_cfg_t        cfg,
  input  logic [SRC_N-1:0] src_pwr,
  input  logic             gate,
  output logic             hs_en,
  output logic             ddc_en,
  output logic             pwr_sel
);
  always_comb begin
    pwr_sel = pick_pwr(src_pwr, cfg.sel);
    hs_en   = hs_enable(cfg, pwr_sel);
    ddc_en  = ddc_enable(cfg, pwr_sel, gate);
  end

  assert_hs_needs_power_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hs_en |-> (src_pwr[cfg.sel] && !cfg.oe_n));
  assert_ddc_needs_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ddc_en |-> cfg.ddc_en);
  assert_ddc_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !src_pwr[cfg.sel]) |-> !ddc_en);
endmodule

// File: rtl/vsw_hpd_route.sv
module vsw_hpd_route
  import vsw_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SNK_N*SEL_W-1:0]      sel_flat,
  input  logic [SNK_N-1:0]            snk_hpd,
  input  logic                        prio,
  output logic [SRC_N-1:0]            src_hpd
);
  logic [SRC_N-1:0][SNK_N-1:0] claim;

  always_comb begin
    for (int s = 0; s < SRC_N; s++) begin
      for (int k = 0; k < SNK_N; k++)
        claim[s][k] = (sel_flat[k*SEL_W +: SEL_W] == SEL_W'(s));
      src_hpd[s] = claim[s][prio] ? snk_hpd[prio] : |(claim[s] & snk_hpd);
    end
  end

  for (genvar s = 0; s < SRC_N; s++) begin : g_chk
    assert_unselected_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[SEL_W-1:0] != SEL_W'(s) && sel_flat[2*SEL_W-1:SEL_W] != SEL_W'(s))
        |-> !src_hpd[s]);
    assert_shared_follows_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_flat[SEL_W-1:0] == SEL_W'(s) && sel_flat[2*SEL_W-1:SEL_W] == SEL_W'(s))
        |-> (src_hpd[s] == (prio ? snk_hpd[1] : snk_hpd[0])));
  end
endmodule

// File: rtl/vsw_route_ctrl.sv
module vsw_route_ctrl
  import vsw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     gpio_mode,
  input  logic [SNK_N*SEL_W-1:0]   gpio_sel,
  input  logic [SNK_N-1:0]         gpio_oe_n,
  input  logic [SNK_N-1:0]         gpio_ddc_en,
  input  logic                     gpio_prio,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [DATA_W-1:0]        reg_wdata,
  input  logic [SRC_N-1:0]         src_pwr,
  input  logic [SNK_N-1:0]         snk_hpd,
  output logic [SRC_N-1:0]         src_hpd,
  output logic [SRC_N-1:0]         src_ddc_en,
  output logic [SNK_N*SEL_W-1:0]   snk_sel,
  output logic [SNK_N-1:0]         snk_hs_en,
  output logic [SNK_N-1:0]         snk_ddc_en,
  output logic [SNK_N-1:0]         snk_pwr
);
  localparam int PIN_W = 2 + 2*SNK_N + SNK_N*SEL_W;

  logic [PIN_W-1:0]      pin_raw, pin_sync;
  logic                  mode_s, prio_s;
  logic [SNK_N-1:0]      oe_n_s, ddc_s;
  logic [SNK_N*SEL_W-1:0] sel_s;

  sink_cfg_t [SNK_N-1:0] reg_sink, pin_sink, live_sink;
  glob_cfg_t             reg_glob;
  logic                  live_prio, live_gate;

  assign pin_raw = {gpio_mode, gpio_prio, gpio_ddc_en, gpio_oe_n, gpio_sel};

  vsw_cfg_sync #(.W(PIN_W)) i_sync (
    .clk (clk), .rst_n (rst_n), .din (pin_raw), .dout (pin_sync)
  );

  assign {mode_s, prio_s, ddc_s, oe_n_s, sel_s} = pin_sync;

  vsw_cfg_regs i_regs (
    .clk (clk), .rst_n (rst_n), .we (reg_we), .addr (reg_addr),
    .wdata (reg_wdata), .sink_q (reg_sink), .glob_q (reg_glob)
  );

  always_comb begin
    for (int k = 0; k < SNK_N; k++) begin
      pin_sink[k].sel    = sel_s[k*SEL_W +: SEL_W];
      pin_sink[k].oe_n   = oe_n_s[k];
      pin_sink[k].ddc_en = ddc_s[k];
    end
    live_sink = mode_s ? pin_sink : reg_sink;
    live_prio = mode_s ? prio_s : reg_glob.prio;
    live_gate = mode_s | reg_glob.pwr_gate;
  end

  for (genvar k = 0; k < SNK_N; k++) begin : g_sink
    assign snk_sel[k*SEL_W +: SEL_W] = live_sink[k].sel;
    vsw_sink_path i_path (
      .clk (clk), .rst_n (rst_n), .cfg (live_sink[k]), .src_pwr (src_pwr),
      .gate (live_gate), .hs_en (snk_hs_en[k]), .ddc_en (snk_ddc_en[k]),
      .pwr_sel (snk_pwr[k])
    );
  end

  vsw_hpd_route i_hpd (
    .clk (clk), .rst_n (rst_n), .sel_flat (snk_sel), .snk_hpd (snk_hpd),
    .prio (live_prio), .src_hpd (src_hpd)
  );

  assign src_ddc_en = src_pwr;

  // pin mode never lets the DDC path open without source power
  assert_pin_mode_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && !snk_pwr[0]) |-> !snk_ddc_en[0]);
endmodule

// File: tb/test_vsw_route_ctrl.sv
module test_vsw_route_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gpio_mode = 1'b0, gpio_prio = 1'b0, reg_we = 1'b0;
  logic [3:0] gpio_sel = '0, src_pwr = '0;
  logic [1:0] gpio_oe_n = '0, gpio_ddc_en = '0, snk_hpd = '0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [3:0] src_hpd, src_ddc_en, snk_sel;
  logic [1:0] snk_hs_en, snk_ddc_en, snk_pwr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vsw_route_ctrl i_vsw_route_ctrl (.*);

  // sel[22:19] oe_n[18:17] ddc[16:15] prio[14] pwr[13:10] hpd[9:8] | exp src_hpd[7:4] hs[3:2] ddc[1:0]
  localparam logic [22:0] VEC [8] = '{
    23'b0100_00_11_0_1111_11_0011_11_11,
    23'b1110_00_11_0_0100_01_0100_01_01,
    23'b0101_00_11_0_0010_10_0000_11_11,
    23'b0101_00_11_1_0010_10_0010_11_11,
    23'b1111_01_10_1_1000_11_1000_10_10,
    23'b1000_00_11_0_0000_11_0101_00_00,
    23'b0011_10_01_0_1001_01_1000_01_01,
    23'b1001_00_11_1_0110_10_0100_11_11
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [1:0] exp_pwr(input logic [3:0] sel, input logic [3:0] pwr);
    logic [1:0] r;
    for (int k = 0; k < 2; k++) r[k] = pwr[(sel >> (2*k)) & 4'd3];
    return r;
  endfunction

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R10 reset state, no power
    check("R10 sel", 8'(snk_sel), 8'hF);
    check("R10 hs", 8'(snk_hs_en), 8'h0);
    check("R10 ddc", 8'(snk_ddc_en), 8'h0);
    check("R10 src_hpd", 8'(src_hpd), 8'h0);
    src_pwr = 4'b1000; snk_hpd = 2'b01;
    wait_n(1);
    check("R10 hs powered", 8'(snk_hs_en), 8'h3);
    check("R1 snk_pwr", 8'(snk_pwr), 8'h3);
    check("R4 shared prio0", 8'(src_hpd), 8'b1000);
    check("R7 src_ddc", 8'(src_ddc_en), 8'b1000);
    snk_hpd = 2'b10;
    wait_n(1);
    check("R4 shared prio0 other", 8'(src_hpd), 8'h0);

    // R8 register mode
    src_pwr = 4'b0000;
    wr(8'd1, 8'h08); wr(8'd2, 8'h0D); wr(8'd3, 8'h00);
    check("R8 sel", 8'(snk_sel), 8'b0100);
    check("R5 gate off ddc", 8'(snk_ddc_en), 8'h3);
    check("R2 no power hs", 8'(snk_hs_en), 8'h0);
    src_pwr = 4'b0011;
    wait_n(1);
    check("R2 oe_n", 8'(snk_hs_en), 8'b01);
    wr(8'd3, 8'h10); src_pwr = 4'b0010;
    wait_n(1);
    check("R5 gate on ddc", 8'(snk_ddc_en), 8'b10);
    wr(8'd0, 8'hFF); wr(8'd4, 8'hFF);
    check("R8 bad addr sel", 8'(snk_sel), 8'b0100);
    check("R8 bad addr ddc", 8'(snk_ddc_en), 8'b10);
    snk_hpd = 2'b01;
    wr(8'd1, 8'hE1);
    check("R8 reserved bits", 8'(snk_sel), 8'b0101);
    check("R4 reg prio0", 8'(src_hpd), 8'b0010);
    wr(8'd3, 8'h30);
    check("R4 reg prio1", 8'(src_hpd), 8'b0000);

    // R6 pin mode overrides gate bit
    wr(8'd3, 8'h00);
    src_pwr = 4'b0000;
    gpio_sel = 4'b0000; gpio_oe_n = 2'b00; gpio_ddc_en = 2'b11; gpio_prio = 1'b0; gpio_mode = 1'b1;
    wait_n(3);
    check("R6 pin gates ddc", 8'(snk_ddc_en), 8'h0);
    check("R6 pin sel", 8'(snk_sel), 8'h0);
    // R9 two-edge latency
    gpio_sel = 4'b1110;
    wait_n(1);
    check("R9 edge1 old", 8'(snk_sel), 8'h0);
    wait_n(1);
    check("R9 edge2 new", 8'(snk_sel), 8'b1110);

    // vector table in pin mode
    foreach (VEC[i]) begin
      gpio_sel = VEC[i][22:19]; gpio_oe_n = VEC[i][18:17]; gpio_ddc_en = VEC[i][16:15];
      gpio_prio = VEC[i][14]; src_pwr = VEC[i][13:10]; snk_hpd = VEC[i][9:8];
      wait_n(3);
      check($sformatf("R3 vec%0d src_hpd", i), 8'(src_hpd), 8'(VEC[i][7:4]));
      check($sformatf("R2 vec%0d hs", i), 8'(snk_hs_en), 8'(VEC[i][3:2]));
      check($sformatf("R5 vec%0d ddc", i), 8'(snk_ddc_en), 8'(VEC[i][1:0]));
      check($sformatf("R1 vec%0d pwr", i), 8'(snk_pwr), 8'(exp_pwr(VEC[i][22:19], VEC[i][13:10])));
      check($sformatf("R7 vec%0d src_ddc", i), 8'(src_ddc_en), 8'(VEC[i][13:10]));
    end

    // R6 back to register mode, gate off
    gpio_mode = 1'b0; src_pwr = 4'b0000;
    wait_n(3);
    check("R6 reg sel", 8'(snk_sel), 8'b0101);
    check("R6 reg ddc", 8'(snk_ddc_en), 8'b10);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule